// File: doc/BRIEF.md
# Asynchronous Memory Bus Controller

This block connects an internal request stream to an external asynchronous device, such as an FPGA register file or an SRAM. Each request carries an address, a direction, write data and a "more follows" flag. The block turns each request into one bus access made of three phases: setup, strobe and hold. It drives an active-low chip select, a write strobe and an output-enable strobe, together with the address and the write data.

A single 32-bit configuration word sets the timing. It holds separate setup, strobe and hold counts for reads and for writes, a turnaround count, and a data-width code. Read data is captured at the end of the read strobe and returned with a one-cycle valid pulse. Chip select can stay low across a run of contiguous requests. It goes high whenever the stream has a gap, and it also goes high for the turnaround cycles inserted between a write and a read.

The request port is valid/ready. The producer holds `req_valid` and the request fields steady until it sees `req_ready` high at a clock edge. `req_ready` is high while the block is idle. During an access it is high only in the final hold cycle, and only if that access carried the "more follows" flag. At every other time the producer is back-pressured. The read response has no back-pressure, so the consumer must take `rsp_rdata` in the cycle `rsp_valid` is high. The configuration word should only change while the bus is idle.

Top module: `amem_ctrl`

## Requirements
- R1: The configuration word is decoded as follows. Write setup is in bits 29:26, write strobe in 25:20 and write hold in 19:17. Read setup is in 16:13, read strobe in 12:7 and read hold in 6:4. The turnaround count is in 3:2 and the width code is in 1:0.
- R2: A write runs setup, strobe and hold, and each phase lasts its field value plus one clock. Chip select is low for all three phases. The write strobe is low only during the strobe phase.
- R3: A read uses the read fields in the same way, with the output-enable strobe low only during the read strobe phase. The write strobe and the output-enable strobe are never low together, and neither is ever low while chip select is high.
- R4: Bus read data is sampled on the last clock of the read strobe phase. `rsp_valid` is high for exactly one cycle, the cycle right after that clock.
- R5: `req_ready` is high while idle. During an access it is high only in the final hold cycle of an access whose "more follows" flag was set, and it is never high during a strobe.
- R6: If a request with "more follows" set is followed by a same-direction request accepted in its final hold cycle, chip select stays low with no high cycle between the two accesses.
- R7: If the flag is clear, or no request is waiting at the final hold cycle, chip select goes high for at least one cycle before the next access.
- R8: If the direction of an accepted request differs from that of the previous access, chip select stays high for the turnaround value plus one cycles before setup begins.
- R9: Width code 0 selects an 8-bit device: the upper byte of the driven write data is zero, and read data returns the low bus byte with zeros above it. Any other code selects 16 bits.
- R10: The address and write data stay stable for the whole of an access. The data drive enable `bus_doe` is high for every write phase and never during a read.
- R11: After reset, chip select and both strobes are high, `req_ready` is high, and `rsp_valid` and `bus_doe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg | input | 32 | Timing and width configuration word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_more | input | 1 | Another request follows back to back |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | DATA_W | Read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_oe_n | output | 1 | Output-enable strobe, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_dout | output | DATA_W | Write data to the device |
| bus_doe | output | 1 | Drive enable for bus_dout |
| bus_din | input | DATA_W | Read data from the device |

## Verification
The bench measures the length of each strobe and each chip-select pulse for two different configuration words. A design that mis-sliced a field, or that added one cycle too few, would produce pulse lengths that differ from the field values plus one. It checks that chip select does not rise between chained writes, and that it does rise when the flag is clear or when no follower arrives. A controller that always released chip select would fail the first of these checks, and one that held it through idle would fail the second. It also measures the number of high cycles at a write-to-read change for two turnaround values, and it runs 8-bit mode in both directions, where leaking upper bytes would show up on the bus or in the response.

// File: rtl/amem_pkg.sv
package amem_pkg;
  localparam int SETUP_W  = 4;
  localparam int STROBE_W = 6;
  localparam int HOLD_W   = 3;
  localparam int TURN_W   = 2;
  localparam int CNT_W    = STROBE_W;

  // field LSB positions inside the configuration word
  localparam int WS_LSB  = 26;
  localparam int WST_LSB = 20;
  localparam int WH_LSB  = 17;
  localparam int RS_LSB  = 13;
  localparam int RST_LSB = 7;
  localparam int RH_LSB  = 4;
  localparam int TA_LSB  = 2;
  localparam int WID_LSB = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_SETUP, ST_STROBE, ST_HOLD
  } amem_state_t;

  typedef struct packed {
    logic [SETUP_W-1:0]  setup;
    logic [STROBE_W-1:0] strobe;
    logic [HOLD_W-1:0]   hold;
  } amem_phase_t;
endpackage

// File: rtl/amem_cfg_decode.sv
module amem_cfg_decode
  import amem_pkg::*;
(
  input  logic [31:0]       cfg_word,
  output amem_phase_t       wr_phase,
  output amem_phase_t       rd_phase,
  output logic [TURN_W-1:0] turn_cnt,
  output logic              wide
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_word[31:WS_LSB+SETUP_W];

  assign wr_phase.setup  = cfg_word[WS_LSB  +: SETUP_W];
  assign wr_phase.strobe = cfg_word[WST_LSB +: STROBE_W];
  assign wr_phase.hold   = cfg_word[WH_LSB  +: HOLD_W];
  assign rd_phase.setup  = cfg_word[RS_LSB  +: SETUP_W];
  assign rd_phase.strobe = cfg_word[RST_LSB +: STROBE_W];
  assign rd_phase.hold   = cfg_word[RH_LSB  +: HOLD_W];
  assign turn_cnt        = cfg_word[TA_LSB  +: TURN_W];
  assign wide            = (cfg_word[WID_LSB +: 2] != 2'd0);
endmodule

// File: rtl/amem_seq.sv
module amem_seq
  import amem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_more,
  input  amem_phase_t       wr_phase,
  input  amem_phase_t       rd_phase,
  input  logic [TURN_W-1:0] turn_cnt,
  output logic              req_ready,
  output logic              accept,
  output amem_state_t       state,
  output logic              cur_wr,
  output logic              strobe_last
);
  logic [CNT_W-1:0] cnt;
  logic             cur_more;
  logic             have_prev;
  amem_phase_t      cur_ph;
  amem_phase_t      nxt_ph;
  logic             cnt_zero;
  logic             need_turn;

  assign cnt_zero    = (cnt == '0);
  assign cur_ph      = cur_wr ? wr_phase : rd_phase;
  assign nxt_ph      = req_write ? wr_phase : rd_phase;
  assign need_turn   = have_prev && (req_write != cur_wr);
  assign req_ready   = (state == ST_IDLE) || (state == ST_HOLD && cnt_zero && cur_more);
  assign accept      = req_valid && req_ready;
  assign strobe_last = (state == ST_STROBE) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      cur_wr    <= 1'b0;
      cur_more  <= 1'b0;
      have_prev <= 1'b0;
    end else if (accept) begin
      cur_wr    <= req_write;
      cur_more  <= req_more;
      have_prev <= 1'b1;
      if (need_turn) begin
        state <= ST_TURN;
        cnt   <= CNT_W'(turn_cnt);
      end else begin
        state <= ST_SETUP;
        cnt   <= CNT_W'(nxt_ph.setup);
      end
    end else begin
      unique case (state)
        ST_TURN: begin
          if (cnt_zero) begin
            state <= ST_SETUP;
            cnt   <= CNT_W'(cur_ph.setup);
          end else cnt <= cnt - 1'b1;
        end
        ST_SETUP: begin
          if (cnt_zero) begin
            state <= ST_STROBE;
            cnt   <= CNT_W'(cur_ph.strobe);
          end else cnt <= cnt - 1'b1;
        end
        ST_STROBE: begin
          if (cnt_zero) begin
            state <= ST_HOLD;
            cnt   <= CNT_W'(cur_ph.hold);
          end else cnt <= cnt - 1'b1;
        end
        ST_HOLD: begin
          if (cnt_zero) state <= ST_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amem_rdcap.sv
module amem_rdcap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              wide,
  input  logic [DATA_W-1:0] bus_din,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int NARROW_W = DATA_W / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture)
        rsp_rdata <= wide ? bus_din : DATA_W'(bus_din[NARROW_W-1:0]);
    end
  end
endmodule

// File: rtl/amem_ctrl.sv
module amem_ctrl
  import amem_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_more,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_cs_n,
  output logic              bus_we_n,
  output logic              bus_oe_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din
);
  localparam int NARROW_W = DATA_W / 2;

  amem_phase_t       wr_phase, rd_phase;
  logic [TURN_W-1:0] turn_cnt;
  logic              wide;
  logic              accept;
  amem_state_t       state;
  logic              cur_wr;
  logic              strobe_last;
  logic              active;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dout_q;

  amem_cfg_decode u_dec (
    .cfg_word (cfg),
    .wr_phase (wr_phase),
    .rd_phase (rd_phase),
    .turn_cnt (turn_cnt),
    .wide     (wide)
  );

  amem_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_more    (req_more),
    .wr_phase    (wr_phase),
    .rd_phase    (rd_phase),
    .turn_cnt    (turn_cnt),
    .req_ready   (req_ready),
    .accept      (accept),
    .state       (state),
    .cur_wr      (cur_wr),
    .strobe_last (strobe_last)
  );

  amem_rdcap #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (strobe_last && !cur_wr),
    .wide      (wide),
    .bus_din   (bus_din),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      dout_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      dout_q <= wide ? req_wdata : DATA_W'(req_wdata[NARROW_W-1:0]);
    end
  end

  assign active   = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign bus_cs_n = !active;
  assign bus_we_n = !((state == ST_STROBE) && cur_wr);
  assign bus_oe_n = !((state == ST_STROBE) && !cur_wr);
  assign bus_doe  = active && cur_wr;
  assign bus_addr = addr_q;
  assign bus_dout = dout_q;
endmodule

// File: rtl/amem_ctrl_chk.sv
module amem_ctrl_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       cfg,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              bus_cs_n,
  input logic              bus_we_n,
  input logic              bus_oe_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_dout,
  input logic              bus_doe
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_we_n && !bus_oe_n)); // R3
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we_n || !bus_oe_n) |-> !bus_cs_n); // R3
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4
  AST_RSP_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!bus_oe_n) && bus_oe_n)); // R4
  AST_NO_READY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we_n || !bus_oe_n) |-> !req_ready); // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n) && !$past(req_valid && req_ready))
      |-> ($stable(bus_addr) && $stable(bus_dout))); // R10
  AST_DOE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> bus_doe); // R10
  AST_NO_DOE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> !bus_doe); // R10
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_doe && cfg[1:0] == 2'd0) |-> (bus_dout[DATA_W-1:DATA_W/2] == '0)); // R9
endmodule

bind amem_ctrl amem_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/amem_ctrl_tb.sv
`timescale 1ns/1ps
module amem_ctrl_tb;
  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   cfg = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_more = 1'b0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          bus_cs_n, bus_we_n, bus_oe_n, bus_doe;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout;
  logic [DW-1:0] bus_din;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction
  assign bus_din = bus_oe_n ? 16'h0000 : model(bus_addr);

  amem_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_more(req_more),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din)
  );

  // configuration word builder, field positions per R1
  function automatic logic [31:0] mkcfg(input int ws, input int wst, input int wh,
                                        input int rs, input int rst, input int rh,
                                        input int ta, input int wid);
    logic [31:0] c;
    c = '0;
    c[29:26] = 4'(ws);  c[25:20] = 6'(wst); c[19:17] = 3'(wh);
    c[16:13] = 4'(rs);  c[12:7]  = 6'(rst); c[6:4]   = 3'(rh);
    c[3:2]   = 2'(ta);  c[1:0]   = 2'(wid);
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // bus monitor, sampled on the falling edge
  int we_run, oe_run, cs_run, hi_run;
  int last_we_len, last_oe_len, last_cs_len, last_gap;
  int we_pulses, oe_pulses, cs_falls, rsp_cnt, doe_bad;
  logic seen_low, prev_cs_n, prev_oe_low, rsp_ok;
  logic [DW-1:0] last_wd, last_rd;
  logic [AW-1:0] last_wa;

  initial begin
    we_run = 0; oe_run = 0; cs_run = 0; hi_run = 0;
    prev_cs_n = 1'b1; prev_oe_low = 1'b0;
  end

  always @(negedge clk) begin
    if (!bus_we_n) begin
      we_run++; last_wd = bus_dout; last_wa = bus_addr;
    end else if (we_run != 0) begin
      last_we_len = we_run; we_pulses++; we_run = 0;
    end
    if (!bus_oe_n) oe_run++;
    else if (oe_run != 0) begin
      last_oe_len = oe_run; oe_pulses++; oe_run = 0;
    end
    if (!bus_cs_n) begin
      if (prev_cs_n) begin
        if (seen_low) last_gap = hi_run;
        cs_falls++;
      end
      seen_low = 1'b1; cs_run++; hi_run = 0;
      if (bus_doe != !bus_we_n && !bus_we_n) doe_bad++;
    end else begin
      if (!prev_cs_n) begin last_cs_len = cs_run; cs_run = 0; end
      hi_run++;
      if (bus_doe) doe_bad++;
    end
    if (rsp_valid) begin
      rsp_cnt++; last_rd = rsp_rdata;
      if (!(prev_oe_low && bus_oe_n)) rsp_ok = 1'b0;
    end
    prev_cs_n = bus_cs_n;
    prev_oe_low = !bus_oe_n;
  end

  task automatic clear_mon();
    @(posedge clk);
    last_we_len = 0; last_oe_len = 0; last_cs_len = 0; last_gap = -1;
    we_pulses = 0; oe_pulses = 0; cs_falls = 0; rsp_cnt = 0; doe_bad = 0;
    seen_low = 1'b0; rsp_ok = 1'b1; last_wd = '0; last_wa = '0; last_rd = '0;
    @(negedge clk);
  endtask

  // present one request at a falling edge, return one falling edge after acceptance
  task automatic send(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic m);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_more = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 cs_n", 32'(bus_cs_n), 1);
    chk("R11 we_n", 32'(bus_we_n), 1);
    chk("R11 oe_n", 32'(bus_oe_n), 1);
    chk("R11 ready", 32'(req_ready), 1);
    chk("R11 rsp_valid", 32'(rsp_valid), 0);
    chk("R11 doe", 32'(bus_doe), 0);
  endtask

  task automatic t_write_single(input int ws, input int wst, input int wh, input string tag);
    clear_mon();
    send(1'b1, 20'h01234, 16'hBEEF, 1'b0);
    chk({tag, " R5 ready low mid-access"}, 32'(req_ready), 0);
    settle();
    chk({tag, " R2 we_n low length"}, 32'(last_we_len), 32'(wst + 1));
    chk({tag, " R2 cs_n low length"}, 32'(last_cs_len), 32'(ws + wst + wh + 3));
    chk({tag, " R3 no oe during write"}, 32'(oe_pulses), 0);
    chk({tag, " R10 write data"}, 32'(last_wd), 32'h0000BEEF);
    chk({tag, " R10 write addr"}, 32'(last_wa), 32'h01234);
    chk({tag, " R10 doe pattern"}, 32'(doe_bad), 0);
  endtask

  task automatic t_read_single(input int rs, input int rst, input int rh, input string tag);
    clear_mon();
    send(1'b0, 20'h0A5A5, 16'h0, 1'b0);
    settle();
    chk({tag, " R3 oe_n low length"}, 32'(last_oe_len), 32'(rst + 1));
    chk({tag, " R3 cs_n low length"}, 32'(last_cs_len), 32'(rs + rst + rh + 3));
    chk({tag, " R3 no we during read"}, 32'(we_pulses), 0);
    chk({tag, " R4 one rsp pulse"}, 32'(rsp_cnt), 1);
    chk({tag, " R4 rsp after last oe"}, 32'(rsp_ok), 1);
    chk({tag, " R4 read data"}, 32'(last_rd), 32'(model(20'h0A5A5)));
    chk({tag, " R10 doe off"}, 32'(doe_bad), 0);
  endtask

  task automatic t_chain_writes();
    clear_mon();
    send(1'b1, 20'h00010, 16'h1111, 1'b1);
    send(1'b1, 20'h00011, 16'h2222, 1'b1);
    send(1'b1, 20'h00012, 16'h3333, 1'b0);
    settle();
    chk("R6 single cs fall for chain", 32'(cs_falls), 1);
    chk("R6 three write strobes", 32'(we_pulses), 3);
    chk("R6 chain cs length", 32'(last_cs_len), 32'(3 * 8));
    chk("R6 last write data", 32'(last_wd), 32'h3333);
  endtask

  task automatic t_gap_writes();
    clear_mon();
    send(1'b1, 20'h00020, 16'hAAAA, 1'b0);
    send(1'b1, 20'h00021, 16'h5555, 1'b0);
    settle();
    chk("R7 cs falls per access", 32'(cs_falls), 2);
    chk("R7 one-cycle gap", 32'(last_gap), 1);
    chk("R7 both writes", 32'(we_pulses), 2);
  endtask

  task automatic t_more_no_follow();
    clear_mon();
    send(1'b1, 20'h00030, 16'h7777, 1'b1);
    settle();
    chk("R7 cs released without follower", 32'(bus_cs_n), 1);
    chk("R7 cs length", 32'(last_cs_len), 8);
    chk("R5 ready back when idle", 32'(req_ready), 1);
  endtask

  task automatic t_turn(input int ta);
    clear_mon();
    send(1'b1, 20'h00040, 16'h4444, 1'b1);
    send(1'b0, 20'h00041, 16'h0, 1'b0);
    settle();
    chk($sformatf("R8 turnaround gap ta=%0d", ta), 32'(last_gap), 32'(ta + 1));
    chk("R8 read completed", 32'(rsp_cnt), 1);
    chk("R8 read data", 32'(last_rd), 32'(model(20'h00041)));
  endtask

  task automatic t_narrow();
    clear_mon();
    send(1'b1, 20'h00050, 16'h12AB, 1'b0);
    send(1'b0, 20'h0C3F1, 16'h0, 1'b0);
    settle();
    chk("R9 narrow write data", 32'(last_wd), 32'h00AB);
    chk("R9 narrow read data", 32'(last_rd), 32'({8'h00, model(20'h0C3F1)[7:0]}));
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cfg = mkcfg(1, 3, 1, 0, 6, 0, 0, 1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_single(1, 3, 1, "cfgA");
    t_read_single(0, 6, 0, "cfgA");
    t_chain_writes();
    t_gap_writes();
    t_more_no_follow();
    t_turn(0);
    cfg = mkcfg(1, 3, 1, 0, 6, 0, 2, 1);
    t_turn(2);
    cfg = mkcfg(3, 0, 2, 2, 1, 4, 1, 1);
    t_write_single(3, 0, 2, "R1 cfgB");
    t_read_single(2, 1, 4, "R1 cfgB");
    cfg = mkcfg(1, 3, 1, 0, 6, 0, 0, 0);
    t_narrow();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule